// File: doc/BRIEF.md
# Dual-Mode Serial Converter Output Port

This block is the digital serial port of a 16-bit sampling converter, written as a synthesizable slave that runs on a system clock. A rising edge on the convert input starts a conversion. The conversion time is modelled as a fixed number of system clocks. When that count ends, the block captures the parallel result word into a shift register. At the same rising edge the block reads the level of the serial data input, and that level fixes the port's behaviour until the next conversion.

The block has two modes. In chip-select mode, the serial output is driven only while the convert input or the serial data input is held low. The port can also raise a busy indication that drops to a ready marker when the result is available. In daisy-chain mode, the output is always driven. The block first shifts out its own 16 bits and then forwards the bits arriving on the serial data input, so several converters can share one readout line. The convert, serial clock and serial data inputs are brought into the system clock domain through two-flop synchronizers, and all edge detection happens in that domain. The output enable stands in for a tri-state pad.

Top module: `sdoSerialPort`

## Requirements
- R1: After reset the port is in chip-select mode, no conversion is running and the shift register holds zero. With the convert input low, the output is therefore driven at 0.
- R2: A detected rising edge of the convert input selects the mode from the serial data input level at that edge: 1 selects chip-select mode, 0 selects daisy-chain mode. The mode then holds until the next rising edge.
- R3: A conversion lasts CONV_CYCLES system clocks after its rising edge is detected. At its end, the shift register is loaded from the parallel result input.
- R4: In chip-select mode, the output enable is 1 exactly while the synchronized convert input or serial data input is low, and 0 when both are high.
- R5: The result leaves MSB first. Bit 15 is on the output before any serial clock falling edge, each falling edge advances the output by one bit, and zeros follow bit 0.
- R6: In chip-select mode, while a conversion runs and the output is enabled, the output is 1 (busy).
- R7: In chip-select mode, if the output is enabled at the moment a conversion completes, the output goes to 0 as a ready marker. The first falling edge after that presents bit 15, and later edges proceed as in R5.
- R8: Serial clock edges that occur during a conversion do not move the shift register.
- R9: In daisy-chain mode the output enable is always 1.
- R10: In daisy-chain mode, the serial data level captured at falling edge k appears on the output after falling edge k+15. The upstream bits therefore follow the block's own 16 bits with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cnvIn | input | 1 | Convert start; its rising edge begins a conversion and latches the mode |
| sclkIn | input | 1 | Serial clock from the host; the output advances on its falling edge |
| sdiIn | input | 1 | Mode select at convert rise; then a second enable (chip-select) or the chain data input |
| sampleIn | input | 16 | Parallel conversion result, captured when the conversion ends |
| sdoOut | output | 1 | Serial data output value |
| sdoOe | output | 1 | Output enable of the serial data pad |

## Verification
The hardest case to reach from the ports is the ready marker. It appears only when the serial data input drops after the convert edge has already picked chip-select mode and stays low through the end of the conversion. The bench raises the convert input with the data input high, pulls the data input low while the conversion runs, and issues a serial clock pulse inside the conversion window. It then checks the busy level, the 0 marker and a full MSB-first readout that the ignored pulse must not have shifted. Daisy-chain forwarding is checked by driving a computed upstream bit on every falling edge and comparing each output slot past the sixteenth against the bit sent fifteen edges earlier.

// File: rtl/sdo_port_pkg.sv
package sdo_port_pkg;

  // Strobes from the control to the shift datapath
  typedef struct packed {
    logic loadWord;   // capture the parallel result
    logic shiftBit;   // advance by one bit toward the MSB
    logic insertBit;  // bit entering at the LSB on a shift
  } dpStrobes_t;

endpackage

// File: rtl/syncBank.sv
module syncBank #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] levelOut
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe <= '0;
    end else begin
      pipe[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign levelOut = pipe[STAGES-1];

endmodule

// File: rtl/sdoPortCtrl.sv
module sdoPortCtrl
  import sdo_port_pkg::*;
#(
  parameter int CONV_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cnvLvl,
  input  logic       sclkLvl,
  input  logic       sdiLvl,
  input  logic       wordMsb,
  output dpStrobes_t strobes,
  output logic       sdoOut,
  output logic       sdoOe,
  output logic       converting,
  output logic       chainMode
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(CONV_CYCLES - 1);

  logic             cnvPrev;
  logic             sclkPrev;
  logic             busyMark;
  logic [CNT_W-1:0] convCount;

  logic cnvRise, sclkFall, convEnd, enableLow, edgeUsable, markClear;

  assign cnvRise    = cnvLvl & ~cnvPrev;
  assign sclkFall   = ~sclkLvl & sclkPrev;
  assign convEnd    = converting && (convCount == LAST_COUNT);
  assign enableLow  = ~cnvLvl | ~sdiLvl;
  assign edgeUsable = sclkFall & ~converting & ~cnvRise;
  assign markClear  = edgeUsable & ~chainMode & enableLow & busyMark;

  always_comb begin
    strobes.loadWord  = convEnd & ~cnvRise;
    strobes.shiftBit  = edgeUsable & (chainMode | (enableLow & ~busyMark));
    strobes.insertBit = chainMode & sdiLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnvPrev    <= 1'b0;
      sclkPrev   <= 1'b0;
      converting <= 1'b0;
      chainMode  <= 1'b0;
      busyMark   <= 1'b0;
      convCount  <= '0;
    end else begin
      cnvPrev  <= cnvLvl;
      sclkPrev <= sclkLvl;
      if (cnvRise) begin
        converting <= 1'b1;
        convCount  <= '0;
        chainMode  <= ~sdiLvl;
        busyMark   <= 1'b0;
      end else if (converting) begin
        if (convEnd) begin
          converting <= 1'b0;
          busyMark   <= ~chainMode & enableLow;
        end else begin
          convCount <= convCount + 1'b1;
        end
      end else if (markClear) begin
        busyMark <= 1'b0;
      end
    end
  end

  always_comb begin
    if (chainMode)       sdoOut = wordMsb;
    else if (converting) sdoOut = 1'b1;
    else if (busyMark)   sdoOut = 1'b0;
    else                 sdoOut = wordMsb;
    sdoOe = chainMode | enableLow;
  end

endmodule

// File: rtl/shiftPath.sv
module shiftPath
  import sdo_port_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [WORD_W-1:0] sampleIn,
  output logic [WORD_W-1:0] shiftWord,
  output logic              wordMsb
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord <= '0;
    end else if (strobes.loadWord) begin
      shiftWord <= sampleIn;
    end else if (strobes.shiftBit) begin
      shiftWord <= {shiftWord[WORD_W-2:0], strobes.insertBit};
    end
  end

  assign wordMsb = shiftWord[WORD_W-1];

endmodule

// File: rtl/sdoSerialPort.sv
module sdoSerialPort
  import sdo_port_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cnvIn,
  input  logic              sclkIn,
  input  logic              sdiIn,
  input  logic [WORD_W-1:0] sampleIn,
  output logic              sdoOut,
  output logic              sdoOe
);

  localparam int N_ASYNC = 3;

  logic [N_ASYNC-1:0] levels;
  logic               cnvLvl, sclkLvl, sdiLvl;
  dpStrobes_t         strobes;
  logic [WORD_W-1:0]  shiftWord;
  logic               wordMsb;
  logic               converting;
  logic               chainMode;

  syncBank #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .asyncIn  ({cnvIn, sclkIn, sdiIn}),
    .levelOut (levels)
  );

  assign {cnvLvl, sclkLvl, sdiLvl} = levels;

  sdoPortCtrl #(.CONV_CYCLES(CONV_CYCLES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cnvLvl     (cnvLvl),
    .sclkLvl    (sclkLvl),
    .sdiLvl     (sdiLvl),
    .wordMsb    (wordMsb),
    .strobes    (strobes),
    .sdoOut     (sdoOut),
    .sdoOe      (sdoOe),
    .converting (converting),
    .chainMode  (chainMode)
  );

  shiftPath #(.WORD_W(WORD_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sampleIn  (sampleIn),
    .shiftWord (shiftWord),
    .wordMsb   (wordMsb)
  );

endmodule

// File: rtl/sdoSerialPortChk.sv
module sdoSerialPortChk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              converting,
  input logic              chainMode,
  input logic              sdoOut,
  input logic              sdoOe,
  input logic [WORD_W-1:0] shiftWord,
  input logic [WORD_W-1:0] sampleIn
);

  // R9: a chained port never releases the line
  p_chain_driven_r9: assert property (@(posedge clk) disable iff (!rstN)
    chainMode |-> sdoOe);

  // R6: an enabled chip-select port shows busy high while converting
  p_busy_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (converting && !chainMode && sdoOe) |-> sdoOut);

  // R2: the mode only changes at a conversion start
  p_mode_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chainMode) |-> converting);

  // R3: the end of a conversion captures the parallel word
  p_load_word_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(converting) |-> (shiftWord == $past(sampleIn)));

  // R8: the shift register is frozen inside a conversion
  p_sclk_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (converting && $past(converting)) |-> $stable(shiftWord));

endmodule

bind sdoSerialPort sdoSerialPortChk #(.WORD_W(WORD_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .converting (converting),
  .chainMode  (chainMode),
  .sdoOut     (sdoOut),
  .sdoOe      (sdoOe),
  .shiftWord  (shiftWord),
  .sampleIn   (sampleIn)
);

// File: tb/sdoSerialPort_test.sv
module sdoSerialPort_test;

  localparam int CLK_PERIOD  = 10;
  localparam int WORD_W      = 16;
  localparam int CONV_CYCLES = 40;
  localparam int WATCHDOG    = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cnvIn = 1'b0;
  logic              sclkIn = 1'b0;
  logic              sdiIn = 1'b1;
  logic [WORD_W-1:0] sampleIn = '0;
  logic              sdoOut;
  logic              sdoOe;

  int  checkCount = 0;
  int  failCount  = 0;
  bit  finished   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdoSerialPort #(.WORD_W(WORD_W), .CONV_CYCLES(CONV_CYCLES)) uut (
    .clk(clk), .rstN(rstN), .cnvIn(cnvIn), .sclkIn(sclkIn), .sdiIn(sdiIn),
    .sampleIn(sampleIn), .sdoOut(sdoOut), .sdoOe(sdoOe)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkBit(input string req, input logic actual, input logic expected);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s actual=%0b expected=%0b", req, actual, expected);
    end
  endtask

  task automatic pulseSclk();
    sclkIn = 1'b1;
    waitClk(4);
    sclkIn = 1'b0;
    waitClk(6);
  endtask

  // Start a conversion with the mode level modeSdi on the data input
  task automatic startConv(input logic modeSdi);
    cnvIn = 1'b0;
    waitClk(6);
    sdiIn = modeSdi;
    waitClk(4);
    cnvIn = 1'b1;
    waitClk(6);
  endtask

  // Chip-select readout; enSel 0 = convert input enables, 1 = data input enables
  task automatic csRead(input logic [WORD_W-1:0] word, input bit enSel, input bit busy);
    sampleIn = word;
    startConv(1'b1);
    if (busy) begin
      sdiIn = 1'b0;
      waitClk(5);
      checkBit("R6 busy level", sdoOut, 1'b1);
      checkBit("R6 busy enable", sdoOe, 1'b1);
    end else begin
      checkBit("R4 released during conversion", sdoOe, 1'b0);
    end
    pulseSclk();  // R8: falls inside the conversion window
    waitClk(CONV_CYCLES);
    if (busy) begin
      checkBit("R7 ready marker", sdoOut, 1'b0);
      pulseSclk();
      checkBit("R7 msb after marker", sdoOut, word[WORD_W-1]);
    end else begin
      checkBit("R4 released after conversion", sdoOe, 1'b0);
      if (enSel) sdiIn = 1'b0; else cnvIn = 1'b0;
      waitClk(5);
      checkBit("R4 enabled", sdoOe, 1'b1);
      checkBit("R5 R8 msb first", sdoOut, word[WORD_W-1]);
    end
    for (int b = WORD_W - 2; b >= 0; b--) begin
      pulseSclk();
      checkBit("R5 bit order", sdoOut, word[b]);
    end
    pulseSclk();
    checkBit("R5 trailing zero", sdoOut, 1'b0);
    if (enSel || busy) begin
      sdiIn = 1'b1;
      waitClk(5);
      checkBit("R4 released by data input", sdoOe, 1'b0);
    end
  endtask

  // Daisy-chain readout with a computed upstream stream
  task automatic chainRead(input logic [WORD_W-1:0] word, input int seed);
    logic [47:1] upstream;
    logic        expBit;
    sampleIn = word;
    startConv(1'b0);
    sdiIn = 1'b1;
    waitClk(4);
    checkBit("R2 R9 chain driven in conversion", sdoOe, 1'b1);
    pulseSclk();  // R8
    waitClk(CONV_CYCLES);
    checkBit("R9 chain driven", sdoOe, 1'b1);
    checkBit("R8 chain msb", sdoOut, word[WORD_W-1]);
    for (int m = 1; m <= 47; m++) upstream[m] = 1'(((m * 7 + seed) >> 2) ^ (m * seed));
    for (int m = 1; m <= 47; m++) begin
      sdiIn = upstream[m];
      waitClk(3);
      pulseSclk();
      if (m <= WORD_W - 1) expBit = word[WORD_W-1-m];
      else                 expBit = upstream[m-15];
      checkBit(m <= WORD_W - 1 ? "R10 own bit" : "R10 forwarded bit", sdoOut, expBit);
    end
    checkBit("R9 chain driven after readout", sdoOe, 1'b1);
  endtask

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    checkBit("R1 reset data", sdoOut, 1'b0);
    checkBit("R1 reset enable", sdoOe, 1'b1);

    for (int i = 0; i < WORD_W; i++) csRead(WORD_W'(1) << i, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) csRead(WORD_W'(16'h9E37 * (i + 1) ^ 16'h5A5A), 1'b1, 1'b0);
    csRead(16'hFFFF, 1'b0, 1'b0);
    csRead(16'h0000, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) csRead(WORD_W'(16'hC3A1 + 16'h1357 * i), 1'b1, 1'b1);
    csRead(16'h8001, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) chainRead(WORD_W'(16'hB2E4 ^ (16'h0F0F << i)), i + 3);
    chainRead(16'h0000, 11);
    chainRead(16'hFFFF, 5);

    // R2: after chain mode, a high mode level brings back chip-select release
    sampleIn = 16'h4321;
    startConv(1'b1);
    waitClk(2);
    checkBit("R2 back to chip-select", sdoOe, 1'b0);
    waitClk(CONV_CYCLES);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule